// File: doc/BRIEF.md
# Endpoint DMA request generator

This block produces the level DMA request for one endpoint FIFO. The endpoint is either a transmit or a receive endpoint. It holds the endpoint's transmit-done and receive-last status flags, along with a last-byte flag that firmware sets through a command strobe. A firmware read of the status register clears all three flags. The block also holds the DMA enable bit, which firmware writes.

A hold-mode input picks one of two release rules. In flag mode the request follows the status flags, and a status read removes it. In warning mode the request follows the FIFO warning level. In receive operation an empty FIFO always removes the request.

The request is only raised while both the endpoint enable and the DMA enable are on. When either gate goes off, a request that the DMA controller is already serving is held until that cycle ends.

Top module: `epdma_req_gen`

## Requirements
- R1: After a cycle with `rst_n` low, the outputs `dma_req`, `dma_en`, `tx_done_flag` and `rx_last_flag` are all 0.
- R2: `dma_req` rises only on an edge where `ep_en` and `dma_en` were both 1. If `ep_en` is 0 and `dma_req` is 0, `dma_req` stays 0 at the next edge.
- R3: Transmit endpoint (`dir_tx`=1) in flag mode (`hold_mode`=0): the next `dma_req` is the next transmit-done flag AND NOT the next last-byte flag.
- R4: Transmit endpoint in flag mode: a `stat_rd` strobe (which clears transmit-done) or a `last_cmd` strobe removes the request at the same edge that updates the flags.
- R5: Transmit endpoint in warning mode (`hold_mode`=1): the next `dma_req` is `fifo_warn` AND NOT the next transmit-done flag.
- R6: Receive endpoint (`dir_tx`=0) in flag mode: the next `dma_req` is the next receive-last flag AND NOT `fifo_empty`. A `stat_rd` strobe therefore drops the request at the edge where the flag clears.
- R7: Receive endpoint in warning mode: the next `dma_req` is `fifo_warn` AND NOT `fifo_empty`.
- R8: Each flag has its own rules. `tx_done_set` sets transmit-done. `rx_last_set` sets receive-last. `last_cmd` sets last-byte. `stat_rd` clears all three at the next edge. A set strobe in the same cycle as `stat_rd` wins.
- R9: When the gate `ep_en & dma_en` is 0, `dma_req` stays 1 at the next edge only if it is already 1, `dma_ack` is 1 and the rule condition still holds. Otherwise it drops at the next edge.
- R10: With `dma_en_wr`=1, `dma_en` loads `dma_en_wdata` at the next edge when `serial_strap`=0. It loads 0 when `serial_strap`=1, so a write of 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_strap | input | 1 | Serial-interface strap; blocks setting DMA enable |
| dma_en_wr | input | 1 | Firmware write strobe for the DMA enable bit |
| dma_en_wdata | input | 1 | Value written to the DMA enable bit |
| ep_en | input | 1 | Endpoint enable |
| dir_tx | input | 1 | 1 = transmit endpoint, 0 = receive endpoint |
| hold_mode | input | 1 | 0 = flag release rule, 1 = FIFO warning release rule |
| tx_done_set | input | 1 | Transmission completed event |
| rx_last_set | input | 1 | Last byte of a received packet event |
| stat_rd | input | 1 | Firmware status register read strobe |
| last_cmd | input | 1 | Firmware last-byte command strobe |
| fifo_empty | input | 1 | Endpoint FIFO empty |
| fifo_warn | input | 1 | Endpoint FIFO warning level |
| dma_ack | input | 1 | DMA acknowledge, high while a cycle is served |
| dma_req | output | 1 | Registered level DMA request |
| dma_en | output | 1 | DMA enable bit |
| tx_done_flag | output | 1 | Transmit-done status flag |
| rx_last_flag | output | 1 | Receive-last status flag |

## Verification
The bench looks for a status read that clears a flag one edge after the request drops, or one edge before it. Either would leave a spurious request beat, or a missing one, around the read.

It drives a set strobe in the same cycle as a read. A design that gives the read priority would lose a completion event and starve the DMA.

It removes the gate while an acknowledge is high and while it is low. A design that gets this wrong would either cut a cycle that is being served or keep requesting after the enable is gone.

It writes the enable bit with the strap high, and it raises the empty flag in both receive modes. A design that ignores the strap would start DMA in serial operation. One that ignores empty on receive would request reads from a drained FIFO.

// File: rtl/epdma_pkg.sv
// Package: shared types for the endpoint DMA request generator.
// Assumes: one endpoint per instance; all control inputs are synchronous to clk.
package epdma_pkg;
    // Number of sticky status flags kept per endpoint.
    localparam int unsigned NFLAG = 3;
    // Flag slot positions inside the flag vectors.
    localparam int unsigned F_TXD  = 0;
    localparam int unsigned F_RXL  = 1;
    localparam int unsigned F_LAST = 2;

    // Release rule chosen by direction and hold mode.
    typedef enum logic [1:0] {
        RULE_TX_FLAG = 2'b00,
        RULE_TX_WARN = 2'b01,
        RULE_RX_FLAG = 2'b10,
        RULE_RX_WARN = 2'b11
    } epdma_rule_e;

    // Map direction and mode onto a rule.
    function automatic epdma_rule_e pick_rule(input logic is_tx, input logic warn_mode);
        return epdma_rule_e'({~is_tx, warn_mode});
    endfunction
endpackage

// File: rtl/epdma_stflag.sv
// Module: sticky status flag, set by an event strobe, cleared by a read strobe.
// Assumes: a set in the same cycle as a clear wins; the next-state value is
// exported so that dependent logic can act at the same edge.
module epdma_stflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q,
    output logic q_next
);
    // Next-state value with set priority.
    always_comb begin
        q_next = set ? 1'b1 : (clr ? 1'b0 : q);
    end

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_next;
    end

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
    a_r8_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/epdma_enreg.sv
// Module: DMA enable bit, written by firmware.
// Assumes: the serial-interface strap forbids setting the bit; the bit resets to 0.
module epdma_enreg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    input  logic strap,
    output logic q
);
    // Enable register; a write loads the data masked by the strap.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= 1'b0;
        else if (wr) q <= wdata & ~strap;
    end

    a_r10_strap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && strap) |=> !q);
    a_r10_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !strap) |=> (q == $past(wdata)));
endmodule

// File: rtl/epdma_cond.sv
// Module: request condition for the selected release rule.
// Assumes: flag inputs are the next-state values, so a status read or a set
// event changes the condition at the same edge as the flag itself.
module epdma_cond
    import epdma_pkg::*;
(
    input  epdma_rule_e rule,
    input  logic        txd_n,
    input  logic        rxl_n,
    input  logic        last_n,
    input  logic        fifo_empty,
    input  logic        fifo_warn,
    output logic        cond
);
    // Select the condition that keeps the request raised.
    always_comb begin
        unique case (rule)
            RULE_TX_FLAG: cond = txd_n & ~last_n;
            RULE_TX_WARN: cond = fifo_warn & ~txd_n;
            RULE_RX_FLAG: cond = rxl_n & ~fifo_empty;
            RULE_RX_WARN: cond = fifo_warn & ~fifo_empty;
            default:      cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/epdma_req_gen.sv
// Module: endpoint DMA request generator (top).
// Holds the status flags and the DMA enable bit, and drives a registered level
// request. The request follows the release rule while the endpoint and DMA are
// enabled; with the gate off it is held only while an acknowledged cycle runs.
// Assumes: dir_tx and hold_mode are quasi-static configuration.
module epdma_req_gen
    import epdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic serial_strap,
    input  logic dma_en_wr,
    input  logic dma_en_wdata,
    input  logic ep_en,
    input  logic dir_tx,
    input  logic hold_mode,
    input  logic tx_done_set,
    input  logic rx_last_set,
    input  logic stat_rd,
    input  logic last_cmd,
    input  logic fifo_empty,
    input  logic fifo_warn,
    input  logic dma_ack,
    output logic dma_req,
    output logic dma_en,
    output logic tx_done_flag,
    output logic rx_last_flag
);
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_n;
    logic             cond;
    logic             gate;
    logic             req_d;

    // Gather the set strobes of the flags.
    always_comb begin
        flag_set         = '0;
        flag_set[F_TXD]  = tx_done_set;
        flag_set[F_RXL]  = rx_last_set;
        flag_set[F_LAST] = last_cmd;
    end

    // One sticky flag per slot, all cleared by a status read.
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        epdma_stflag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (flag_set[i]),
            .clr    (stat_rd),
            .q      (flag_q[i]),
            .q_next (flag_n[i])
        );
    end

    epdma_enreg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (dma_en_wr),
        .wdata (dma_en_wdata),
        .strap (serial_strap),
        .q     (dma_en)
    );

    epdma_cond u_cond (
        .rule       (pick_rule(dir_tx, hold_mode)),
        .txd_n      (flag_n[F_TXD]),
        .rxl_n      (flag_n[F_RXL]),
        .last_n     (flag_n[F_LAST]),
        .fifo_empty (fifo_empty),
        .fifo_warn  (fifo_warn),
        .cond       (cond)
    );

    // Next request: follow the rule when gated on, else drain an acknowledged cycle.
    always_comb begin
        gate  = ep_en & dma_en;
        req_d = gate ? cond : (dma_req & dma_ack & cond);
    end

    // Registered request output, cleared synchronously on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_req <= 1'b0;
        else        dma_req <= req_d;
    end

    assign tx_done_flag = flag_q[F_TXD];
    assign rx_last_flag = flag_q[F_RXL];

    a_r2_disabled_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!ep_en && !dma_req) |=> !dma_req);
    a_r2_rise_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(ep_en && dma_en));
    a_r9_no_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ep_en && dma_en) && !dma_ack) |=> !dma_req);
    a_r7_rx_empty_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_tx && fifo_empty) |=> !dma_req);
    a_r4_last_cmd_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_tx && !hold_mode && last_cmd) |=> !dma_req);
endmodule

// File: tb/epdma_req_gen_test.sv
// Bench: directed corner cases, then a pseudo-random sweep of every input in
// all four configurations, compared each cycle against a requirement model.
module epdma_req_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic serial_strap = 0, dma_en_wr = 0, dma_en_wdata = 0, ep_en = 0;
    logic dir_tx = 0, hold_mode = 0, tx_done_set = 0, rx_last_set = 0;
    logic stat_rd = 0, last_cmd = 0, fifo_empty = 0, fifo_warn = 0, dma_ack = 0;
    logic dma_req, dma_en, tx_done_flag, rx_last_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Model state.
    bit m_req = 0, m_den = 0, m_txd = 0, m_rxl = 0, m_last = 0;
    string auto_tag;

    always #2.5 clk = ~clk;

    epdma_req_gen uut (
        .clk(clk), .rst_n(rst_n), .serial_strap(serial_strap),
        .dma_en_wr(dma_en_wr), .dma_en_wdata(dma_en_wdata), .ep_en(ep_en),
        .dir_tx(dir_tx), .hold_mode(hold_mode), .tx_done_set(tx_done_set),
        .rx_last_set(rx_last_set), .stat_rd(stat_rd), .last_cmd(last_cmd),
        .fifo_empty(fifo_empty), .fifo_warn(fifo_warn), .dma_ack(dma_ack),
        .dma_req(dma_req), .dma_en(dma_en), .tx_done_flag(tx_done_flag),
        .rx_last_flag(rx_last_flag)
    );

    // Advance the model by one edge from the present inputs.
    task automatic model_step();
        bit txd_n, rxl_n, last_n, den_n, c, g;
        if (!rst_n) begin
            m_req = 0; m_den = 0; m_txd = 0; m_rxl = 0; m_last = 0;
            auto_tag = "R1";
            return;
        end
        txd_n  = tx_done_set ? 1'b1 : (stat_rd ? 1'b0 : m_txd);
        rxl_n  = rx_last_set ? 1'b1 : (stat_rd ? 1'b0 : m_rxl);
        last_n = last_cmd    ? 1'b1 : (stat_rd ? 1'b0 : m_last);
        den_n  = dma_en_wr ? (dma_en_wdata & ~serial_strap) : m_den;
        if (dir_tx && !hold_mode) begin
            c = txd_n & ~last_n;
            auto_tag = (stat_rd || last_cmd) ? "R4" : "R3";
        end else if (dir_tx) begin
            c = fifo_warn & ~txd_n;  auto_tag = "R5";
        end else if (!hold_mode) begin
            c = rxl_n & ~fifo_empty; auto_tag = "R6";
        end else begin
            c = fifo_warn & ~fifo_empty; auto_tag = "R7";
        end
        g = ep_en & m_den;
        if (!g) auto_tag = ep_en ? "R9" : "R2";
        m_req = g ? c : (m_req & dma_ack & c);
        m_txd = txd_n; m_rxl = rxl_n; m_last = last_n; m_den = den_n;
    endtask

    // Apply one edge and compare all outputs; tag overrides the automatic one.
    task automatic step(input string tag);
        string t;
        bit [3:0] got, exp;
        model_step();
        @(posedge clk);
        @(negedge clk);
        got = {dma_req, dma_en, tx_done_flag, rx_last_flag};
        exp = {m_req, m_den, m_txd, m_rxl};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            if (tag != "") t = tag;
            else if (got[2] !== exp[2]) t = "R10";
            else if (got[1:0] !== exp[1:0]) t = "R8";
            else t = auto_tag;
            $display("FAIL %s: {req,en,txd,rxl} actual %b expected %b", t, got, exp);
        end
    endtask

    task automatic idle();
        dma_en_wr = 0; tx_done_set = 0; rx_last_set = 0;
        stat_rd = 0; last_cmd = 0; dma_ack = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit [31:0] lf;
        @(negedge clk);
        step("R1");
        step("R1");
        rst_n = 1;
        step("R1");

        // R10: strap blocks setting, then a normal write loads.
        serial_strap = 1; dma_en_wr = 1; dma_en_wdata = 1;
        step("R10");
        serial_strap = 0;
        step("R10");
        idle();

        // R2: events with the endpoint disabled raise nothing.
        dir_tx = 1; hold_mode = 0; tx_done_set = 1;
        step("R2");
        idle(); stat_rd = 1; step("R8"); idle();

        // R3/R4: transmit flag mode, raise, read-clear, last-byte drop.
        ep_en = 1; tx_done_set = 1; step("R3");
        idle(); step("R3");
        stat_rd = 1; step("R4");
        idle(); tx_done_set = 1; step("R3");
        idle(); last_cmd = 1; step("R4");
        idle(); stat_rd = 1; step("R8");
        // R8: set wins over a simultaneous read.
        idle(); tx_done_set = 1; stat_rd = 1; step("R8");
        idle(); step("R3");

        // R9: gate off with and without a served cycle.
        dma_ack = 1; ep_en = 0; step("R9");
        step("R9");
        dma_ack = 0; step("R9");
        idle(); ep_en = 1; stat_rd = 1; step("R8");

        // R5: transmit warning mode.
        idle(); hold_mode = 1; fifo_warn = 1; step("R5");
        fifo_warn = 0; step("R5");
        fifo_warn = 1; tx_done_set = 1; step("R5");
        idle(); stat_rd = 1; step("R5");

        // R6: receive flag mode, empty and read clear it.
        idle(); dir_tx = 0; hold_mode = 0; fifo_warn = 0;
        rx_last_set = 1; step("R6");
        idle(); fifo_empty = 1; step("R6");
        fifo_empty = 0; step("R6");
        stat_rd = 1; step("R6");

        // R7: receive warning mode.
        idle(); hold_mode = 1; fifo_warn = 1; step("R7");
        fifo_empty = 1; step("R7");
        fifo_empty = 0; fifo_warn = 0; step("R7");

        // Sweep every configuration with pseudo-random input vectors.
        lf = 32'h1D2C_3B4A;
        for (int cfg = 0; cfg < 4; cfg++) begin
            dir_tx = cfg[1]; hold_mode = cfg[0];
            for (int k = 0; k < 4000; k++) begin
                lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
                ep_en        = lf[0] | lf[1] | lf[2];
                tx_done_set  = lf[3] & lf[4];
                rx_last_set  = lf[5] & lf[6];
                stat_rd      = lf[7] & lf[8];
                last_cmd     = lf[9] & lf[10] & lf[11];
                fifo_empty   = lf[12] & lf[13];
                fifo_warn    = lf[14];
                dma_ack      = lf[15];
                dma_en_wr    = lf[16] & lf[17] & lf[18];
                dma_en_wdata = lf[19] | lf[20];
                serial_strap = lf[21] & lf[22] & lf[23];
                step("");
            end
        end
        summary();
    end
endmodule